// File: doc/BRIEF.md
# Load Data Alignment and Extension Unit

This unit sits between the read port of a big-endian data memory and a 64-bit register file. For each load request it receives an opcode, the low three bits of the byte address, the current contents of the destination register, and the raw doubleword that the memory returned for the aligned doubleword holding the address. It byte-swaps that doubleword into register order and selects the addressed byte, halfword, word or doubleword. It then produces the value the register file should write back.

Plain loads are sign- or zero-extended to 64 bits. The partial "merge high" and "merge low" loads for words and doublewords splice the fetched bytes into the old register value, and the word forms sign-extend the 32-bit result. A linked word load behaves like a signed word load and also raises a link flag.

Address translation, the memory and exception detection are handled by neighbouring blocks. This unit only takes an exception flag, which suppresses writeback. The result is registered, so the writeback strobe follows the request by one clock.

Top module: `load_align_unit`

## Requirements
- R1: Byte lane k of `mem_raw` (bits 8k+7..8k) holds the byte at aligned-doubleword address base+k. Any multi-byte value is assembled with the lowest address as its most significant byte. `req_offs` bit 2 selects the word, bits 2..1 select the halfword and bits 2..0 select the byte; lower offset bits are ignored for plain loads.
- R2: The signed byte (opcode 0), signed halfword (2) and signed word (4) loads sign-extend the selected value to 64 bits.
- R3: The unsigned byte (1), unsigned halfword (3) and unsigned word (5) loads zero-extend the selected value to 64 bits.
- R4: The doubleword load (6) returns the assembled doubleword unchanged.
- R5: Word merge-high (7): with s = 8*(offs mod 4) and w the word holding the address, the result is the sign extension from bit 31 of ((old & (2^s-1)) | (w << s)).
- R6: Word merge-low (8): with s = 8*(offs mod 4 + 1), let n = sext32(w >> (32-s)) and m = sext32(2^s-1). The result is (old & ~m) | n.
- R7: Doubleword merge-high (9): with s = 8*offs, the result is (old & (2^s-1)) | (d << s), with no extension.
- R8: Doubleword merge-low (10): with s = 8*(offs+1), the result is (old & ~(2^s-1)) | (d >> (64-s)), with no extension.
- R9: A request with `req_exc` high produces no writeback strobe and does not set the link flag.
- R10: A linked load (11) without exception returns the same value as a signed word load and sets `link_flag`. The flag then stays high until reset.
- R11: `wb_valid` and `wb_data` appear on the clock edge that follows the request, and back-to-back requests are accepted every cycle. Opcodes 12 to 31 produce no writeback strobe.
- R12: After synchronous active-low reset, `wb_valid`, `wb_data` and `link_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Load request present this cycle |
| req_op | input | 5 | Load opcode (see requirements) |
| req_offs | input | 3 | Byte offset of the address within its doubleword |
| req_exc | input | 1 | Exception raised for this access; blocks writeback |
| old_reg | input | 64 | Current destination register value |
| mem_raw | input | 64 | Raw aligned doubleword from memory, byte k on lane k |
| wb_valid | output | 1 | Write `wb_data` to the destination register |
| wb_data | output | 64 | Value to write back |
| link_flag | output | 1 | Set by a completed linked load |

## Verification
The bench sweeps every byte offset for each opcode against a memory pattern whose bytes all carry a set top bit. A lane-order or swap error therefore corrupts every value, and a missing extension leaves upper bits clear. The merge offset 0 and full-width merge-low cases are targeted directly: a design that mishandled a 64-bit or 32-bit shift would keep stale old-register bits or lose fetched ones there. Word merge-low at offsets below 3 checks that the upper register half survives. A design that extended those results from the merged word would overwrite it. Exception blocking, unsupported opcodes, the persistence and reset of the link flag, and one-cycle back-to-back timing are each checked at the outputs.

// File: rtl/load_align_pkg.sv
// Shared opcode encoding and helpers for the load alignment unit.
// Assumes a 64-bit register file and big-endian memory byte order.
package load_align_pkg;

    typedef enum logic [4:0] {
        OP_BYTE_S    = 5'd0,
        OP_BYTE_U    = 5'd1,
        OP_HALF_S    = 5'd2,
        OP_HALF_U    = 5'd3,
        OP_WORD_S    = 5'd4,
        OP_WORD_U    = 5'd5,
        OP_DWORD     = 5'd6,
        OP_WMERGE_HI = 5'd7,
        OP_WMERGE_LO = 5'd8,
        OP_DMERGE_HI = 5'd9,
        OP_DMERGE_LO = 5'd10,
        OP_LINKED    = 5'd11
    } ld_op_e;

    // True for every opcode the unit implements.
    function automatic logic op_supported(input logic [4:0] op);
        return op <= 5'd11;
    endfunction

    // True for the four partial merge opcodes.
    function automatic logic op_is_merge(input logic [4:0] op);
        return (op >= 5'd7) && (op <= 5'd10);
    endfunction

endpackage

// File: rtl/load_lane_extract.sv
// Byte-swaps the raw memory doubleword into register order and produces
// the result of every plain (non-merge) load kind.
// Assumes lane k of mem_raw carries the byte at aligned address base+k.
module load_lane_extract
    import load_align_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]         mem_raw,
    input  logic [$clog2(DATA_W/8)-1:0] offs,
    input  logic [4:0]                op,
    output logic [DATA_W-1:0]         dw_be,
    output logic [DATA_W/2-1:0]       word_be,
    output logic [DATA_W-1:0]         plain_result
);
    localparam int BYTES  = DATA_W / 8;
    localparam int OFFS_W = $clog2(BYTES);
    localparam int WORD_W = DATA_W / 2;
    localparam int HALF_W = 16;

    logic [OFFS_W-1:0] byte_sel;
    logic [OFFS_W-2:0] half_sel;
    logic [7:0]        byte_be;
    logic [HALF_W-1:0] half_be;

    // Lane reversal: lowest address becomes most significant byte.
    for (genvar k = 0; k < BYTES; k++) begin : g_swap
        assign dw_be[DATA_W-1-8*k -: 8] = mem_raw[8*k +: 8];
    end

    // Select addressed sub-fields counted from the most significant end.
    always_comb begin
        byte_sel = OFFS_W'(BYTES - 1) - offs;
        half_sel = (OFFS_W-1)'(BYTES/2 - 1) - offs[OFFS_W-1:1];
        byte_be  = dw_be[{byte_sel, 3'b000} +: 8];
        half_be  = dw_be[{half_sel, 4'b0000} +: HALF_W];
        word_be  = offs[OFFS_W-1] ? dw_be[WORD_W-1:0] : dw_be[DATA_W-1:WORD_W];
    end

    // Extend the selected field according to the opcode.
    always_comb begin
        case (op)
            OP_BYTE_S:            plain_result = {{(DATA_W-8){byte_be[7]}}, byte_be};
            OP_BYTE_U:            plain_result = {{(DATA_W-8){1'b0}}, byte_be};
            OP_HALF_S:            plain_result = {{(DATA_W-HALF_W){half_be[HALF_W-1]}}, half_be};
            OP_HALF_U:            plain_result = {{(DATA_W-HALF_W){1'b0}}, half_be};
            OP_WORD_S, OP_LINKED: plain_result = {{WORD_W{word_be[WORD_W-1]}}, word_be};
            OP_WORD_U:            plain_result = {{WORD_W{1'b0}}, word_be};
            OP_DWORD:             plain_result = dw_be;
            default:              plain_result = '0;
        endcase
    end

endmodule

// File: rtl/load_merge.sv
// Splices fetched bytes into the old register value for the word and
// doubleword merge-high / merge-low loads. Word forms sign-extend from
// bit 31; doubleword forms do not extend.
// Assumes word_be / dw_be are already in register byte order.
module load_merge
    import load_align_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]           dw_be,
    input  logic [DATA_W/2-1:0]         word_be,
    input  logic [$clog2(DATA_W/8)-1:0] offs,
    input  logic [DATA_W-1:0]           old_reg,
    input  logic [4:0]                  op,
    output logic [DATA_W-1:0]           merge_result
);
    localparam int BYTES  = DATA_W / 8;
    localparam int OFFS_W = $clog2(BYTES);
    localparam int WORD_W = DATA_W / 2;
    localparam int SH_W   = $clog2(DATA_W) + 1;

    logic [SH_W-1:0]   wh_sh, wl_sh, dh_sh, dl_sh;
    logic [OFFS_W-1:0] wl_bytes;
    logic [OFFS_W:0]   dl_bytes;
    logic [DATA_W-1:0] word_ext, wh_tmp, wl_new, wl_mask, dh_mask, dl_mask;
    logic [DATA_W-1:0] wh_res, wl_res, dh_res, dl_res;

    // Shift amounts in bits derived from the byte offset.
    always_comb begin
        wl_bytes = {1'b0, offs[OFFS_W-2:0]} + OFFS_W'(1);
        dl_bytes = {1'b0, offs} + (OFFS_W+1)'(1);
        wh_sh    = SH_W'({offs[OFFS_W-2:0], 3'b000});
        wl_sh    = SH_W'({wl_bytes, 3'b000});
        dh_sh    = SH_W'({offs, 3'b000});
        dl_sh    = SH_W'({dl_bytes, 3'b000});
    end

    // Word merge-high: keep old low bytes, place word above them.
    always_comb begin
        word_ext = {{WORD_W{1'b0}}, word_be};
        wh_tmp   = (old_reg & ((DATA_W'(1) << wh_sh) - DATA_W'(1))) | (word_ext << wh_sh);
        wh_res   = {{WORD_W{wh_tmp[WORD_W-1]}}, wh_tmp[WORD_W-1:0]};
    end

    // Word merge-low: bring word top bytes down, keep old upper bytes.
    always_comb begin
        wl_new  = word_ext >> (SH_W'(WORD_W) - wl_sh);
        wl_new  = {{WORD_W{wl_new[WORD_W-1]}}, wl_new[WORD_W-1:0]};
        wl_mask = (DATA_W'(1) << wl_sh) - DATA_W'(1);
        wl_mask = {{WORD_W{wl_mask[WORD_W-1]}}, wl_mask[WORD_W-1:0]};
        wl_res  = (old_reg & ~wl_mask) | wl_new;
    end

    // Doubleword merge-high and merge-low, full width, no extension.
    always_comb begin
        dh_mask = (DATA_W'(1) << dh_sh) - DATA_W'(1);
        dh_res  = (old_reg & dh_mask) | (dw_be << dh_sh);
        dl_mask = (DATA_W'(1) << dl_sh) - DATA_W'(1);
        dl_res  = (old_reg & ~dl_mask) | (dw_be >> (SH_W'(DATA_W) - dl_sh));
    end

    // Pick the variant requested by the opcode.
    always_comb begin
        case (op)
            OP_WMERGE_HI: merge_result = wh_res;
            OP_WMERGE_LO: merge_result = wl_res;
            OP_DMERGE_HI: merge_result = dh_res;
            OP_DMERGE_LO: merge_result = dl_res;
            default:      merge_result = old_reg;
        endcase
    end

endmodule

// File: rtl/load_align_unit.sv
// Top of the load alignment unit: selects plain or merge result, registers
// the writeback value and strobe, and keeps the link flag.
// Assumes the exception flag is valid in the same cycle as the request.
module load_align_unit
    import load_align_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [4:0]        req_op,
    input  logic [2:0]        req_offs,
    input  logic              req_exc,
    input  logic [63:0]       old_reg,
    input  logic [63:0]       mem_raw,
    output logic              wb_valid,
    output logic [63:0]       wb_data,
    output logic              link_flag
);
    localparam int WORD_W = DATA_W / 2;

    logic [DATA_W-1:0] dw_be, plain_result, merge_result, next_data;
    logic [WORD_W-1:0] word_be;
    logic              accept;

    load_lane_extract #(.DATA_W(DATA_W)) extract_i (
        .mem_raw      (mem_raw),
        .offs         (req_offs),
        .op           (req_op),
        .dw_be        (dw_be),
        .word_be      (word_be),
        .plain_result (plain_result)
    );

    load_merge #(.DATA_W(DATA_W)) merge_i (
        .dw_be        (dw_be),
        .word_be      (word_be),
        .offs         (req_offs),
        .old_reg      (old_reg),
        .op           (req_op),
        .merge_result (merge_result)
    );

    // A request completes when valid, supported and exception-free.
    always_comb begin
        accept    = req_valid && !req_exc && op_supported(req_op);
        next_data = op_is_merge(req_op) ? merge_result : plain_result;
    end

    // Register the writeback strobe and value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_data  <= '0;
        end else begin
            wb_valid <= accept;
            if (accept) wb_data <= next_data;
        end
    end

    // Sticky link flag raised by a completed linked load.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  link_flag <= 1'b0;
        else if (accept && req_op == OP_LINKED)      link_flag <= 1'b1;
    end

    assert_exc_blocks_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_exc) |=> !wb_valid);

    assert_wb_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(req_valid));

    assert_link_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        link_flag |=> link_flag);

    assert_link_needs_ll_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_flag) |-> $past(req_valid && req_op == OP_LINKED && !req_exc));

    assert_unsigned_byte_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_exc && req_op == OP_BYTE_U) |=> (wb_data[63:8] == '0));

    assert_word_signext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_exc && req_op == OP_WORD_S) |=> (wb_data[63:32] == {32{wb_data[31]}}));

endmodule

// File: tb/load_align_unit_tb.sv
`timescale 1ns/1ps
module load_align_unit_tb_top;
    import load_align_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_op = '0;
    logic [2:0]  req_offs = '0;
    logic        req_exc = 1'b0;
    logic [63:0] old_reg = '0;
    logic [63:0] mem_raw = '0;
    logic        wb_valid;
    logic [63:0] wb_data;
    logic        link_flag;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    localparam logic [63:0] PAT  = 64'hF0E1_D2C3_B4A5_9687;
    localparam logic [63:0] PAT2 = 64'h0817_2635_4453_6271;
    localparam logic [63:0] OLDV = 64'hCAFE_F00D_1357_9BDF;

    always #2.5 clk = ~clk;

    load_align_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_offs(req_offs), .req_exc(req_exc), .old_reg(old_reg),
        .mem_raw(mem_raw), .wb_valid(wb_valid), .wb_data(wb_data),
        .link_flag(link_flag)
    );

    // ---------------- reference model built from the requirements -------
    function automatic logic [63:0] be_dword(input logic [63:0] m);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[63-8*k -: 8] = m[8*k +: 8];
        return r;
    endfunction

    function automatic logic [63:0] sx32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic logic [63:0] model(input int op, input int offs,
                                          input logic [63:0] old, input logic [63:0] m);
        logic [63:0] d, t, msk, nb;
        logic [31:0] w;
        logic [15:0] h;
        logic [7:0]  b;
        int s;
        d = be_dword(m);
        w = (offs >= 4) ? d[31:0] : d[63:32];
        h = d[63-16*(offs/2) -: 16];
        b = d[63-8*offs -: 8];
        case (op)
            0: return {{56{b[7]}}, b};
            1: return {56'b0, b};
            2: return {{48{h[15]}}, h};
            3: return {48'b0, h};
            4, 11: return sx32(w);
            5: return {32'b0, w};
            6: return d;
            7: begin
                s = (offs % 4) * 8;
                t = (old & ((64'd1 << s) - 1)) | ({32'b0, w} << s);
                return sx32(t[31:0]);
            end
            8: begin
                s = (offs % 4 + 1) * 8;
                t = {32'b0, w} >> (32 - s);
                nb = sx32(t[31:0]);
                t = (64'd1 << s) - 1;
                msk = sx32(t[31:0]);
                return (old & ~msk) | nb;
            end
            9: begin
                s = offs * 8;
                msk = (s == 0) ? 64'd0 : ((64'd1 << s) - 1);
                return (old & msk) | (d << s);
            end
            10: begin
                s = (offs + 1) * 8;
                msk = (s == 64) ? '1 : ((64'd1 << s) - 1);
                return (old & ~msk) | ((s == 64) ? d : (d >> (64 - s)));
            end
            default: return 64'd0;
        endcase
    endfunction

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one request, then sample outputs one cycle later at a negedge.
    task automatic issue(input int op, input int offs, input logic [63:0] old,
                         input logic [63:0] m, input logic exc);
        @(negedge clk);
        req_valid = 1'b1; req_op = 5'(op); req_offs = 3'(offs);
        old_reg = old; mem_raw = m; req_exc = exc;
        @(negedge clk);
        req_valid = 1'b0; req_exc = 1'b0;
    endtask

    task automatic sweep(input string tag, input int op, input logic [63:0] m,
                         input logic [63:0] old);
        for (int o = 0; o < 8; o++) begin
            issue(op, o, old, m, 1'b0);
            check({tag, " valid"}, {63'b0, wb_valid}, 64'd1);
            check(tag, wb_data, model(op, o, old, m));
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        // R12: outputs cleared by reset
        check("R12 wb_valid", {63'b0, wb_valid}, 64'd0);
        check("R12 wb_data", wb_data, 64'd0);
        check("R12 link_flag", {63'b0, link_flag}, 64'd0);
    endtask

    task automatic t_exception();
        // R9: exception blocks writeback and link
        issue(11, 0, OLDV, PAT, 1'b1);
        check("R9 no wb on exc", {63'b0, wb_valid}, 64'd0);
        check("R9 no link on exc", {63'b0, link_flag}, 64'd0);
        issue(6, 0, OLDV, PAT, 1'b1);
        check("R9 no wb on exc dword", {63'b0, wb_valid}, 64'd0);
    endtask

    task automatic t_unsupported();
        // R11: opcodes 12..31 give no writeback
        for (int op = 12; op < 32; op += 7) begin
            issue(op, 0, OLDV, PAT, 1'b0);
            check("R11 unsupported op", {63'b0, wb_valid}, 64'd0);
        end
        check("R11 no link from unsupported", {63'b0, link_flag}, 64'd0);
    endtask

    task automatic t_plain();
        sweep("R1 R2 signed byte", 0, PAT, OLDV);
        sweep("R2 signed half", 2, PAT, OLDV);
        sweep("R2 signed word", 4, PAT, OLDV);
        sweep("R2 signed word positive", 4, PAT2, OLDV);
        sweep("R3 unsigned byte", 1, PAT, OLDV);
        sweep("R3 unsigned half", 3, PAT, OLDV);
        sweep("R3 unsigned word", 5, PAT, OLDV);
        sweep("R4 dword", 6, PAT, OLDV);
        // R1: explicit lane order check
        issue(6, 0, 64'd0, 64'h8877_6655_4433_2211, 1'b0);
        check("R1 byte order", wb_data, 64'h1122_3344_5566_7788);
    endtask

    task automatic t_merges();
        sweep("R5 word merge-high", 7, PAT, OLDV);
        sweep("R5 word merge-high pos", 7, PAT2, 64'h0123_4567_89AB_CDEF);
        sweep("R6 word merge-low", 8, PAT, OLDV);
        sweep("R6 word merge-low pos", 8, PAT2, 64'hFFFF_FFFF_FFFF_FFFF);
        sweep("R7 dword merge-high", 9, PAT, OLDV);
        sweep("R8 dword merge-low", 10, PAT, OLDV);
        // R8: offset 7 replaces the whole register
        issue(10, 7, OLDV, PAT2, 1'b0);
        check("R8 full width", wb_data, be_dword(PAT2));
        // R7: offset 0 replaces the whole register
        issue(9, 0, OLDV, PAT2, 1'b0);
        check("R7 full width", wb_data, be_dword(PAT2));
    endtask

    task automatic t_linked();
        // R10: linked load returns signed word and sets link flag
        issue(11, 4, OLDV, PAT, 1'b0);
        check("R10 ll data", wb_data, model(4, 4, OLDV, PAT));
        check("R10 link set", {63'b0, link_flag}, 64'd1);
        issue(6, 0, OLDV, PAT, 1'b0);
        check("R10 link holds", {63'b0, link_flag}, 64'd1);
    endtask

    task automatic t_back_to_back();
        // R11: one-cycle latency, every-cycle acceptance
        @(negedge clk);
        req_valid = 1'b1; req_op = 5'd6; req_offs = 3'd0; old_reg = OLDV;
        mem_raw = PAT; req_exc = 1'b0;
        check("R11 no early wb", {63'b0, wb_valid}, 64'd0);
        @(negedge clk);
        check("R11 first result", wb_data, be_dword(PAT));
        req_op = 5'd1; req_offs = 3'd5;
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 second valid", {63'b0, wb_valid}, 64'd1);
        check("R11 second result", wb_data, model(1, 5, OLDV, PAT));
        @(negedge clk);
        check("R11 strobe drops", {63'b0, wb_valid}, 64'd0);
    endtask

    task automatic t_reset_again();
        // R12 / R10: reset clears link flag and outputs
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        t_reset_state();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_exception();
        t_unsupported();
        t_plain();
        t_merges();
        t_linked();
        t_back_to_back();
        t_reset_again();
        finish_run();
    end

endmodule